// File: doc/BRIEF.md
# SYSREF Capture and Local Multiframe Clock Alignment

This block runs in the link clock domain, which ticks once per beat at lane rate divided by 40. It produces the local multiframe clock (LMFC) as a one-cycle pulse. A beat counter wraps at a programmable period, and the pulse fires when the counter is zero. When the block is set to track an external SYSREF, it synchronizes that input and detects rising edges. It then reloads the counter so that the beat carrying the edge becomes the programmed offset beat.

Three modes exist. In the off mode, SYSREF is ignored and the counter simply free-runs. In the continuous mode, every edge is checked and a misplaced edge re-aligns the counter. In the oneshot mode, the first edge fixes the phase and every later edge is ignored. In both tracking modes, `lmfc_valid` stays low and no pulse is produced until an edge has been taken. Downstream logic that needs the LMFC waits on `lmfc_valid`.

Two sticky status bits record that an edge was taken and that an edge arrived off-phase. Each bit is cleared by a one-cycle clear strobe. The offset is written in octets at four octets per beat, and the block reads it back in the same unit.

Top module: `mfclk_align`

## Requirements
- R1: While reset is held, and right after it, both status bits are 0, `lmfc_valid` is 1 and the beat counter is at 0.
- R2: With `cfg_mode` at 0 (off) or 3 (spare, treated as off), the LMFC free-runs with one pulse every `cfg_period_m1`+1 beats. `lmfc_valid` is 1, SYSREF never sets a status bit and SYSREF never moves the phase.
- R3: A SYSREF edge counts when the input is 0 at one clock sample and 1 at the next. The edge acts at the second rising clock edge after the first high sample.
- R4: When an edge is taken, the clock cycle in which it acts counts as beat `offset`. The beat counter then continues from there and wraps after `cfg_period_m1`, and a pulse marks beat 0. With period 8 and offset 3, the first pulse is visible in the 7th cycle after the first high sample.
- R5: With `cfg_mode` at 1 (continuous) or 2 (oneshot), `lmfc_valid` and `lmfc_pulse` stay low until an edge has been taken in the current mode.
- R6: In continuous mode, every edge is taken. An edge that acts while the counter is not at the offset beat sets `stat_misalign` and re-aligns the counter. An edge that acts at the offset beat changes nothing.
- R7: In oneshot mode, edges after the first have no effect on the phase or on either status bit.
- R8: `stat_captured` is set in the cycle after an edge is taken and stays set until it is cleared.
- R9: A 1 on `clr_captured` or `clr_misalign` clears the matching bit one cycle later. If a set and a clear arrive in the same cycle, the set wins.
- R10: `cfg_offset_oct` is in octets, at four octets per beat. Its two low bits are ignored, and `offset_rb_oct` returns the value with those bits read as 0.
- R11: Any change of `cfg_mode` drops the captured lock at the next clock edge. An edge acting in that same cycle is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock, one beat per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| sysref_in | input | 1 | External SYSREF, asynchronous |
| cfg_mode | input | 2 | 0 off, 1 continuous, 2 oneshot, 3 off |
| cfg_period_m1 | input | 8 | LMFC period in beats minus one |
| cfg_offset_oct | input | 10 | LMFC offset in octets |
| clr_captured | input | 1 | Clear strobe for the captured bit |
| clr_misalign | input | 1 | Clear strobe for the misalign bit |
| lmfc_pulse | output | 1 | One-cycle LMFC pulse at beat 0 |
| lmfc_valid | output | 1 | High when the LMFC phase is usable |
| stat_captured | output | 1 | Sticky: a SYSREF edge was taken |
| stat_misalign | output | 1 | Sticky: an edge arrived off-phase |
| offset_rb_oct | output | 10 | Offset read back in octets |

## Verification
A wrong beat count or a wrong reload value shows up as a pulse in the wrong cycle. That error appears at most one LMFC period after an edge is taken. A lock flag stuck high or low shows up as `lmfc_valid` set wrongly, visible one cycle after a mode change or one cycle after the first edge is taken. A status bit that is set or cleared wrongly is visible on the cycle after its trigger. The bench compares every output against a behavioural model on every clock, so any of these errors is caught within one period.

// File: rtl/mfa_pkg.sv
`timescale 1ns/1ps
package mfa_pkg;

    typedef enum logic [1:0] {
        SR_OFF   = 2'd0,
        SR_CONT  = 2'd1,
        SR_ONCE  = 2'd2,
        SR_SPARE = 2'd3
    } sr_mode_e;

    localparam int EV_CAPTURED = 0;
    localparam int EV_MISALIGN = 1;
    localparam int EV_COUNT    = 2;

    function automatic logic mode_tracks(input sr_mode_e m);
        return (m == SR_CONT) || (m == SR_ONCE);
    endfunction

endpackage

// File: rtl/mfa_sysref_sync.sv
`timescale 1ns/1ps
module mfa_sysref_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sysref_in,
    output logic sysref_edge
);
    localparam int CHAIN_W = STAGES + 1;

    typedef struct packed {
        logic [CHAIN_W-1:0] chain;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[CHAIN_W-2:0], sysref_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // rising edge on the synchronized copy against its registered delay
    assign sysref_edge = st_q.chain[STAGES-1] & ~st_q.chain[STAGES];

endmodule

// File: rtl/mfa_beat_counter.sv
`timescale 1ns/1ps
module mfa_beat_counter #(
    parameter int BEAT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BEAT_W-1:0] period_m1,
    input  logic [BEAT_W-1:0] offset_beats,
    input  logic              load,
    output logic [BEAT_W-1:0] cnt,
    output logic              at_offset
);
    typedef struct packed {
        logic [BEAT_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    function automatic logic [BEAT_W-1:0] step(input logic [BEAT_W-1:0] x,
                                               input logic [BEAT_W-1:0] top);
        return (x >= top) ? '0 : x + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (load) st_d.cnt = step(offset_beats, period_m1);
        else      st_d.cnt = step(st_q.cnt, period_m1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt       = st_q.cnt;
    assign at_offset = (st_q.cnt == offset_beats);

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(period_m1) == period_m1) |-> (st_q.cnt <= period_m1)); // R2

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == period_m1 && !load && $stable(period_m1))
            |=> (st_q.cnt == '0)); // R4

endmodule

// File: rtl/mfa_align_ctrl.sv
`timescale 1ns/1ps
module mfa_align_ctrl
    import mfa_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  sr_mode_e mode,
    input  logic     sysref_edge,
    input  logic     at_offset,
    output logic     align_load,
    output logic     ev_captured,
    output logic     ev_misalign,
    output logic     lmfc_valid
);
    typedef struct packed {
        sr_mode_e mode;
        logic     locked;
    } st_t;

    st_t  st_d, st_q;
    logic mode_chg;
    logic take_edge;

    always_comb begin
        st_d      = st_q;
        mode_chg  = (mode != st_q.mode);
        take_edge = sysref_edge && mode_tracks(mode) && !mode_chg &&
                    ((mode == SR_CONT) || !st_q.locked);

        ev_captured = take_edge;
        ev_misalign = take_edge && st_q.locked && !at_offset;
        align_load  = take_edge;

        st_d.mode   = mode;
        st_d.locked = mode_chg ? 1'b0 : (st_q.locked || take_edge);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode   <= SR_OFF;
            st_q.locked <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lmfc_valid = !mode_tracks(st_q.mode) || st_q.locked;

    AST_LOCK_FROM_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.locked) |-> $past(sysref_edge)); // R5

    AST_MODE_CHG_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != st_q.mode) |=> !st_q.locked); // R11

    AST_ONESHOT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.locked && st_q.mode == SR_ONCE && mode == SR_ONCE) |-> !align_load); // R7

    AST_OFF_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_tracks(mode) |-> !ev_captured); // R2

endmodule

// File: rtl/mfa_sticky_bits.sv
`timescale 1ns/1ps
module mfa_sticky_bits #(
    parameter int NUM = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NUM-1:0] set,
    input  logic [NUM-1:0] clr,
    output logic [NUM-1:0] bits
);
    typedef struct packed {
        logic [NUM-1:0] bits;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.bits = (st_q.bits & ~clr) | set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bits = st_q.bits;

    for (genvar i = 0; i < NUM; i++) begin : g_chk
        AST_STICKY_SET: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> bits[i]); // R8
        AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && !set[i]) |=> !bits[i]); // R9
        AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (bits[i] && !clr[i]) |=> bits[i]); // R8
    end

endmodule

// File: rtl/mfclk_align.sv
`timescale 1ns/1ps
module mfclk_align
    import mfa_pkg::*;
#(
    parameter int BEAT_W      = 8,
    parameter int OPB_LOG2    = 2,
    parameter int SYNC_STAGES = 2,
    localparam int OFS_W      = BEAT_W + OPB_LOG2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sysref_in,
    input  logic [1:0]        cfg_mode,
    input  logic [BEAT_W-1:0] cfg_period_m1,
    input  logic [OFS_W-1:0]  cfg_offset_oct,
    input  logic              clr_captured,
    input  logic              clr_misalign,
    output logic              lmfc_pulse,
    output logic              lmfc_valid,
    output logic              stat_captured,
    output logic              stat_misalign,
    output logic [OFS_W-1:0]  offset_rb_oct
);
    sr_mode_e              mode;
    logic                  sr_edge;
    logic                  align_load;
    logic                  at_offset;
    logic [BEAT_W-1:0]     beat_cnt;
    logic [BEAT_W-1:0]     offset_beats;
    logic [EV_COUNT-1:0]   ev_set;
    logic [EV_COUNT-1:0]   ev_clr;
    logic [EV_COUNT-1:0]   ev_bits;

    assign mode          = sr_mode_e'(cfg_mode);
    assign offset_beats  = cfg_offset_oct[OFS_W-1:OPB_LOG2];
    assign offset_rb_oct = {offset_beats, {OPB_LOG2{1'b0}}};

    mfa_sysref_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .sysref_in   (sysref_in),
        .sysref_edge (sr_edge)
    );

    mfa_align_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode        (mode),
        .sysref_edge (sr_edge),
        .at_offset   (at_offset),
        .align_load  (align_load),
        .ev_captured (ev_set[EV_CAPTURED]),
        .ev_misalign (ev_set[EV_MISALIGN]),
        .lmfc_valid  (lmfc_valid)
    );

    mfa_beat_counter #(.BEAT_W(BEAT_W)) u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .period_m1    (cfg_period_m1),
        .offset_beats (offset_beats),
        .load         (align_load),
        .cnt          (beat_cnt),
        .at_offset    (at_offset)
    );

    assign ev_clr[EV_CAPTURED] = clr_captured;
    assign ev_clr[EV_MISALIGN] = clr_misalign;

    mfa_sticky_bits #(.NUM(EV_COUNT)) u_stat (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (ev_set),
        .clr   (ev_clr),
        .bits  (ev_bits)
    );

    assign stat_captured = ev_bits[EV_CAPTURED];
    assign stat_misalign = ev_bits[EV_MISALIGN];
    assign lmfc_pulse    = lmfc_valid && (beat_cnt == '0);

    AST_ERR_ONLY_CONT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_misalign) |-> ($past(cfg_mode) == SR_CONT)); // R6

    AST_LOAD_AT_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        (align_load && $stable(cfg_offset_oct) && $stable(cfg_period_m1) &&
         offset_beats < cfg_period_m1) |=> (beat_cnt == offset_beats + 1'b1)); // R4

endmodule

// File: tb/mfclk_align_test.sv
`timescale 1ns/1ps
module mfclk_align_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sysref_in = 1'b0;
    logic [1:0] cfg_mode = 2'd0;
    logic [7:0] cfg_period_m1 = 8'd7;
    logic [9:0] cfg_offset_oct = 10'd13;
    logic       clr_captured = 1'b0;
    logic       clr_misalign = 1'b0;
    logic       lmfc_pulse, lmfc_valid, stat_captured, stat_misalign;
    logic [9:0] offset_rb_oct;

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 0;
    string phase   = "reset";

    always #4 clk = ~clk;

    mfclk_align uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .sysref_in      (sysref_in),
        .cfg_mode       (cfg_mode),
        .cfg_period_m1  (cfg_period_m1),
        .cfg_offset_oct (cfg_offset_oct),
        .clr_captured   (clr_captured),
        .clr_misalign   (clr_misalign),
        .lmfc_pulse     (lmfc_pulse),
        .lmfc_valid     (lmfc_valid),
        .stat_captured  (stat_captured),
        .stat_misalign  (stat_misalign),
        .offset_rb_oct  (offset_rb_oct)
    );

    task automatic chk(input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s [%s]: got %0d expected %0d", req, what, phase, act, exp);
        end
    endtask

    // behavioural reference model
    int mcnt;
    bit mlock, mcap, merr;
    int mmode;
    bit sq[$];

    function automatic int wrapnext(input int x, input int top);
        return (x >= top) ? 0 : x + 1;
    endfunction

    always @(posedge clk) begin
        bit e, chg, en, acc;
        int off, top;
        if (!rst_n) begin
            sq = {1'b0, 1'b0, 1'b0};
            mcnt = 0; mlock = 0; mmode = 0; mcap = 0; merr = 0;
        end else begin
            top = cfg_period_m1;
            off = cfg_offset_oct / 4;
            e   = sq[$-1] && !sq[$-2];
            chg = (cfg_mode != mmode);
            en  = (cfg_mode == 1) || (cfg_mode == 2);
            acc = e && en && !chg && ((cfg_mode == 1) || !mlock);
            merr = (merr && !clr_misalign) || (acc && mlock && (mcnt != off));
            mcap = (mcap && !clr_captured) || acc;
            mcnt = acc ? wrapnext(off, top) : wrapnext(mcnt, top);
            mlock = chg ? 1'b0 : (mlock || acc);
            mmode = cfg_mode;
            sq.push_back(sysref_in);
            if (sq.size() > 6) void'(sq.pop_front());
        end
    end

    always @(negedge clk) begin
        bit mv;
        if (!done) begin
            mv = !((mmode == 1) || (mmode == 2)) || mlock;
            chk("R4", "lmfc_pulse",    lmfc_pulse,    int'(mv && mcnt == 0));
            chk("R5", "lmfc_valid",    lmfc_valid,    int'(mv));
            chk("R8", "stat_captured", stat_captured, int'(mcap));
            chk("R6", "stat_misalign", stat_misalign, int'(merr));
            chk("R10", "offset_rb",    offset_rb_oct, int'(cfg_offset_oct & 10'h3FC));
        end
    end

    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic sr_pulse();
        sysref_in = 1'b1;
        tick(2);
        sysref_in = 1'b0;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog expired: got 0 expected 1");
            done = 1;
            summary();
            $finish;
        end
    end

    initial begin
        int cnt;
        int first;
        tick(3);
        chk("R1", "reset captured", stat_captured, 0);
        chk("R1", "reset misalign", stat_misalign, 0);
        chk("R1", "reset valid",    lmfc_valid,    1);
        rst_n = 1'b1;
        tick(2);

        phase = "off mode";
        cnt = 0;
        for (int i = 0; i < 32; i++) begin
            tick(1);
            if (lmfc_pulse) cnt++;
        end
        chk("R2", "pulses in 32 beats", cnt, 4);
        sr_pulse();
        tick(6);
        chk("R2", "off mode ignores sysref", stat_captured, 0);
        chk("R10", "offset readback", offset_rb_oct, 12);
        cfg_mode = 2'd3;
        tick(2);
        chk("R2", "spare mode valid", lmfc_valid, 1);

        phase = "continuous";
        cfg_mode = 2'd1;
        tick(1);
        chk("R11", "valid drops on mode change", lmfc_valid, 0);
        cnt = 0;
        for (int i = 0; i < 20; i++) begin
            tick(1);
            if (lmfc_pulse) cnt++;
        end
        chk("R5", "no pulse before capture", cnt, 0);
        sysref_in = 1'b1;
        first = 0;
        for (int i = 1; i <= 40; i++) begin
            tick(1);
            if (i == 2) sysref_in = 1'b0;
            if (lmfc_pulse && first == 0) begin
                first = i;
                break;
            end
        end
        chk("R3", "first pulse cycle after edge", first, 7);
        chk("R8", "captured set", stat_captured, 1);
        chk("R6", "no misalign on first edge", stat_misalign, 0);
        tick(9);
        sr_pulse();
        tick(10);
        chk("R6", "aligned edge no error", stat_misalign, 0);
        tick(3);
        sr_pulse();
        tick(8);
        chk("R6", "misaligned edge flags", stat_misalign, 1);
        clr_misalign = 1'b1;
        tick(1);
        clr_misalign = 1'b0;
        tick(1);
        chk("R9", "misalign cleared", stat_misalign, 0);
        clr_captured = 1'b1;
        tick(1);
        clr_captured = 1'b0;
        tick(1);
        chk("R9", "captured cleared", stat_captured, 0);
        sysref_in = 1'b1;
        tick(2);
        clr_captured = 1'b1;
        sysref_in = 1'b0;
        tick(1);
        clr_captured = 1'b0;
        chk("R9", "set wins over clear", stat_captured, 1);
        tick(4);

        phase = "oneshot";
        cfg_mode = 2'd2;
        tick(1);
        chk("R11", "valid drops entering oneshot", lmfc_valid, 0);
        tick(3);
        sr_pulse();
        tick(6);
        chk("R5", "oneshot valid after edge", lmfc_valid, 1);
        chk("R8", "oneshot captured", stat_captured, 1);
        clr_captured = 1'b1;
        clr_misalign = 1'b1;
        tick(1);
        clr_captured = 1'b0;
        clr_misalign = 1'b0;
        tick(5);
        sr_pulse();
        tick(8);
        chk("R7", "later edge no capture", stat_captured, 0);
        chk("R7", "later edge no misalign", stat_misalign, 0);
        tick(12);

        phase = "new period";
        cfg_mode = 2'd0;
        cfg_period_m1 = 8'd4;
        cfg_offset_oct = 10'd11;
        tick(12);
        cfg_mode = 2'd1;
        tick(4);
        sysref_in = 1'b1;
        first = 0;
        for (int i = 1; i <= 40; i++) begin
            tick(1);
            if (i == 2) sysref_in = 1'b0;
            if (lmfc_pulse && first == 0) begin
                first = i;
                break;
            end
        end
        chk("R4", "first pulse, period 5 offset 2", first, 5);
        tick(20);

        done = 1;
        summary();
        $finish;
    end

endmodule